// File: doc/BRIEF.md
# Boot NOP-Feed ROM Gating Controller

This block sits on the read path between an 8-bit processor and its memories. The boot ROM occupies the top of a 64 KB address space. After reset the processor starts fetching at address 0x0000, but no boot code sits there. The controller therefore holds the processor's data input at the no-operation opcode 0x00. Each fetch does nothing except advance the program counter, so the address climbs steadily through the empty low space.

When a qualified read reaches the ROM region, the controller passes that fetch through from the ROM at once and records the release on the clock edge that ends the cycle. From then on, reads at or above the ROM base return ROM data and reads below it return RAM data. A status output shows whether the forced-NOP phase is still in effect. The ROM base is a parameter, for example 0xE000, 0xF000, or 0xFF00 for a one-page ROM.

Top module: `boot_nop_gate`

## Requirements
- R1: After a synchronous reset, `feeding` is 1 and `cpu_data` reads 0x00 whatever values sit on `rom_data` and `ram_data`.
- R2: While `feeding` is 1, a strobed read below `ROM_BASE` returns 0x00, and `feeding` stays 1 after the clock edge.
- R3: While `feeding` is 1, an address at or above `ROM_BASE` with `rd_strobe` low returns 0x00 and does not clear `feeding`.
- R4: While `feeding` is 1, a strobed read at an address at or above `ROM_BASE` returns `rom_data` in the same cycle, with no added latency.
- R5: `feeding` goes to 0 on the clock edge that ends the strobed read described in R4, and not before it.
- R6: After release, any address in the ROM region (`ROM_BASE` up to 0xFFFF) returns `rom_data`.
- R7: After release, any address below `ROM_BASE` returns `ram_data`.
- R8: After release, reads below `ROM_BASE` (including address 0x0000) leave `feeding` at 0. Only reset sets it again.
- R9: A reset applied after release brings back the forced-NOP phase, and the release condition works again from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Processor address bus |
| rd_strobe | input | 1 | Valid memory-read / opcode-fetch cycle |
| rom_data | input | 8 | Data from the boot ROM |
| ram_data | input | 8 | Data from RAM and other low memory |
| cpu_data | output | 8 | Data presented to the processor |
| feeding | output | 1 | 1 while the forced-NOP phase is active |

## Verification
The checker watches, on every cycle, that:
- the output is 0x00 whenever the gate is closed;
- the release happens exactly on a qualified ROM-region read;
- the flag never falls without that read and never comes back without reset;
- after release, the source chosen follows the address.

Only the bench's scenarios can show the system-level behaviour. These are: a long NOP sweep up to the base that ends at the exact base fetch, the first ROM byte reaching the processor in the same cycle, unstrobed glitches into the ROM region having no effect, and a second boot after a mid-run reset.

// File: rtl/boot_gate_pkg.sv
package boot_gate_pkg;

    localparam int DEF_ADDR_W = 16;
    localparam int DEF_DATA_W = 8;
    localparam logic [DEF_ADDR_W-1:0] DEF_ROM_BASE = 16'hE000;

    typedef enum logic {
        PH_RUN  = 1'b0,
        PH_FEED = 1'b1
    } phase_e;

    typedef struct packed {
        logic in_rom;    // address lies in the ROM window
        logic qual_hit;  // strobed read inside the ROM window
    } decode_t;

endpackage

// File: rtl/boot_addr_decode.sv
module boot_addr_decode
    import boot_gate_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter logic [ADDR_W-1:0] ROM_BASE = DEF_ROM_BASE
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    output decode_t           dec
);
    always_comb begin
        dec.in_rom   = (addr >= ROM_BASE);
        dec.qual_hit = rd && (addr >= ROM_BASE);
    end
endmodule

// File: rtl/boot_release_latch.sv
module boot_release_latch
    import boot_gate_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   hit,
    output phase_e phase
);
    always_ff @(posedge clk) begin
        if (rst)
            phase <= PH_FEED;
        else if (phase == PH_FEED && hit)
            phase <= PH_RUN;
    end
endmodule

// File: rtl/boot_data_select.sv
module boot_data_select
    import boot_gate_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter logic [DATA_W-1:0] NOP_CODE = '0
) (
    input  phase_e            phase,
    input  decode_t           dec,
    input  logic [DATA_W-1:0] rom_d,
    input  logic [DATA_W-1:0] ram_d,
    output logic [DATA_W-1:0] out_d
);
    logic open_gate;

    always_comb begin
        open_gate = (phase == PH_RUN) || dec.qual_hit;
        if (!open_gate)
            out_d = NOP_CODE;
        else if (dec.in_rom)
            out_d = rom_d;
        else
            out_d = ram_d;
    end
endmodule

// File: rtl/boot_nop_gate.sv
module boot_nop_gate
    import boot_gate_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W,
    parameter logic [ADDR_W-1:0] ROM_BASE = DEF_ROM_BASE,
    parameter logic [DATA_W-1:0] NOP_CODE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              rd_strobe,
    input  logic [DATA_W-1:0] rom_data,
    input  logic [DATA_W-1:0] ram_data,
    output logic [DATA_W-1:0] cpu_data,
    output logic              feeding
);
    decode_t dec;
    phase_e  phase;

    boot_addr_decode #(.ADDR_W(ADDR_W), .ROM_BASE(ROM_BASE)) u_dec (
        .addr (cpu_addr),
        .rd   (rd_strobe),
        .dec  (dec)
    );

    boot_release_latch u_rel (
        .clk   (clk),
        .rst   (rst),
        .hit   (dec.qual_hit),
        .phase (phase)
    );

    boot_data_select #(.DATA_W(DATA_W), .NOP_CODE(NOP_CODE)) u_sel (
        .phase (phase),
        .dec   (dec),
        .rom_d (rom_data),
        .ram_d (ram_data),
        .out_d (cpu_data)
    );

    assign feeding = (phase == PH_FEED);
endmodule

// File: rtl/boot_nop_gate_chk.sv
module boot_nop_gate_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] ROM_BASE = 16'hE000,
    parameter logic [DATA_W-1:0] NOP_CODE = '0
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              rd_strobe,
    input logic [DATA_W-1:0] rom_data,
    input logic [DATA_W-1:0] ram_data,
    input logic [DATA_W-1:0] cpu_data,
    input logic              feeding
);
    logic hi;
    assign hi = (cpu_addr >= ROM_BASE);

    AST_FEED_NOP: assert property (@(posedge clk) disable iff (rst)
        (feeding && !(rd_strobe && hi)) |-> (cpu_data == NOP_CODE)); // R2

    AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (feeding && !(rd_strobe && hi)) |=> feeding); // R3

    AST_FIRST_ROM_FETCH: assert property (@(posedge clk) disable iff (rst)
        (feeding && rd_strobe && hi) |-> (cpu_data == rom_data)); // R4

    AST_RELEASE_EDGE: assert property (@(posedge clk) disable iff (rst)
        (feeding && rd_strobe && hi) |=> !feeding); // R5

    AST_ROM_AFTER: assert property (@(posedge clk) disable iff (rst)
        (!feeding && hi) |-> (cpu_data == rom_data)); // R6

    AST_RAM_AFTER: assert property (@(posedge clk) disable iff (rst)
        (!feeding && !hi) |-> (cpu_data == ram_data)); // R7

    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        !feeding |=> !feeding); // R8
endmodule

bind boot_nop_gate boot_nop_gate_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROM_BASE(ROM_BASE), .NOP_CODE(NOP_CODE)
) u_chk (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .rd_strobe(rd_strobe),
    .rom_data(rom_data), .ram_data(ram_data), .cpu_data(cpu_data),
    .feeding(feeding)
);

// File: tb/boot_nop_gate_test.sv
module boot_nop_gate_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] BASE = 16'hE000;

    typedef struct {
        logic [7:0] exp_d;
        logic       exp_f;
        string      req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic        rd_strobe = 1'b0;
    logic [7:0]  rom_data = 8'hAA;
    logic [7:0]  ram_data = 8'h55;
    logic [7:0]  cpu_data;
    logic        feeding;

    item_t q[$];
    int    n_checks = 0;
    int    n_fail = 0;
    logic  mfeed = 1'b1;
    logic  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_nop_gate #(.ROM_BASE(BASE)) uut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .rd_strobe(rd_strobe),
        .rom_data(rom_data), .ram_data(ram_data), .cpu_data(cpu_data),
        .feeding(feeding)
    );

    // driver: applies one bus cycle and queues the expected result
    task automatic drive(input logic [15:0] a, input logic s,
                         input logic [7:0] rd, input logic [7:0] rm,
                         input string req);
        item_t it;
        logic  in_rom;
        @(negedge clk);
        cpu_addr = a; rd_strobe = s; rom_data = rd; ram_data = rm;
        in_rom = (a >= BASE);
        it.exp_f = mfeed;
        if (mfeed && !(s && in_rom)) it.exp_d = 8'h00;
        else if (in_rom)             it.exp_d = rd;
        else                         it.exp_d = rm;
        it.req = req;
        if (s && in_rom) mfeed = 1'b0;
        #2;
        q.push_back(it);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        mfeed = 1'b1;
    endtask

    // monitor: pops and compares away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_checks++;
                if (cpu_data !== it.exp_d || feeding !== it.exp_f) begin
                    n_fail++;
                    $display("FAIL %s: data=%02h feed=%b expected data=%02h feed=%b",
                             it.req, cpu_data, feeding, it.exp_d, it.exp_f);
                end
            end
        end
    end

    initial begin
        do_reset();
        // R1: reset state with non-zero memory data
        drive(16'h0000, 1'b1, 8'hFF, 8'hFF, "R1");
        // R2: sweep through low memory
        for (int i = 1; i < 40; i++)
            drive(16'(i), 1'b1, 8'h3C ^ 8'(i), 8'hC3, "R2");
        // R3: unstrobed addresses in the ROM window
        drive(16'hE005, 1'b0, 8'h77, 8'h11, "R3");
        drive(16'hFFFF, 1'b0, 8'h78, 8'h12, "R3");
        drive(BASE,     1'b0, 8'h79, 8'h13, "R3");
        // sweep up to the base
        for (int i = 4; i > 0; i--)
            drive(BASE - 16'(i), 1'b1, 8'h90, 8'h91, "R2");
        // R4: first ROM fetch returns ROM data at once
        drive(BASE, 1'b1, 8'hC3, 8'h00, "R4");
        // R5: flag has fallen by the next cycle
        drive(BASE + 16'h1, 1'b1, 8'h3E, 8'h99, "R5");
        // R6: ROM window after release
        drive(16'hFFFF, 1'b1, 8'h5A, 8'h66, "R6");
        drive(16'hF123, 1'b0, 8'h21, 8'h66, "R6");
        // R7: RAM below the base
        drive(16'h1234, 1'b1, 8'h44, 8'hC7, "R7");
        drive(BASE - 16'h1, 1'b1, 8'h44, 8'hB8, "R7");
        // R8: low reads do not bring the gate back
        drive(16'h0000, 1'b1, 8'h10, 8'h2F, "R8");
        drive(16'h0001, 1'b1, 8'h10, 8'h30, "R8");
        // R9: reset after release, second boot via a higher ROM address
        do_reset();
        drive(BASE, 1'b0, 8'hAB, 8'hCD, "R9");
        drive(16'h0100, 1'b1, 8'hAB, 8'hCD, "R9");
        drive(16'hF000, 1'b1, 8'hE7, 8'hCD, "R9");
        drive(16'h0100, 1'b1, 8'hE7, 8'h4D, "R9");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule